// File: doc/BRIEF.md
# SHA-256 Message Schedule with Round-Addend Lookahead

This block feeds a SHA-256 round engine. It takes a 512-bit block of sixteen message words in a single load cycle. Under a step enable it then produces one schedule word per round. It does not keep the schedule in an indexed array. It keeps a sixteen-word shift window built from flops. The current round's word always sits at one fixed end of that window, and the next word sits right beside it. New words are expanded from fixed taps and shifted in at the far end. This means no round-indexed multiplexer or decoder is ever built.

Next to the word, the block keeps a registered partial sum for the round that is about to run. This lets the round adder chain drop operands. The engine supplies the value its h register will hold after the current update. The block adds to it the round constant of the round being entered. In the two-operand mode it also adds that round's message word. The engine then forms t1 as ch + Σ1 + word + addend in the first mode, or as ch + Σ1 + addend in the second. A parameter selects the mode. The 64 round constants live inside the block as a function of the round index.

Top module: `sha_sched_lookahead`

## Requirements
- R1: After synchronous reset, round_o is 0, word_o is 0 and addend_o is 0.
- R2: A cycle with load_i high takes msg_i as sixteen 32-bit words. Word j sits at bits [511-32j : 480-32j], so word 0 is the top 32 bits. On the next cycle round_o is 0 and word_o is word 0.
- R3: For rounds 1 to 15, word_o after each advance is the loaded word whose index equals round_o.
- R4: For rounds 16 to 63, word_o is s1(w[t-2]) + w[t-7] + s0(w[t-15]) + w[t-16] modulo 2^32. Here s0(x) = rotr7 ^ rotr18 ^ shr3 and s1(x) = rotr17 ^ rotr19 ^ shr10. For example, the block {0x61626380, 0 x14, 0x00000018} gives 0x61626380 at round 16.
- R5: A cycle with step_i high, load_i low and round_o below 63 increments round_o by one and presents that round's word. A cycle with both step_i and load_i low leaves word_o, round_o and addend_o unchanged.
- R6: A step while round_o is 63 is ignored: word_o, round_o and addend_o all hold.
- R7: When load_i and step_i are both high, the load takes effect and the step is discarded.
- R8: With LOOKAHEAD = 1, a load cycle sets addend_o to nxt_h_i + K[0]. An advancing step from round t sets addend_o to nxt_h_i + K[t+1]. Both sums are taken modulo 2^32, with nxt_h_i sampled in that same cycle.
- R9: With LOOKAHEAD = 2, the addend also includes the word of the round being entered. That is nxt_h_i + K[0] + word 0 on load, and nxt_h_i + K[t+1] + w[t+1] on a step.
- R10: K[i] is the first 32 fractional bits of the cube root of the (i+1)-th prime, for i from 0 to 63.
- R11: Reset takes priority over load_i and step_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture msg_i and restart at round 0 |
| msg_i | input | 512 | Sixteen message words, word 0 in the top bits |
| step_i | input | 1 | Advance one round |
| nxt_h_i | input | 32 | Value the engine's h register holds in the round being entered |
| word_o | output | 32 | Message word of the current round |
| round_o | output | 8 | Current round index, 0 to 63 |
| addend_o | output | 32 | Precomputed round addend for the current round |

## Verification
A wrong entry anywhere in the shift window stays hidden until that entry reaches the output tap. That happens after at most fifteen steps, and a corrupted expansion term first shows at round 16. Comparing every word of a full 64-round run on every clock therefore catches window and expansion faults, each within one block. A wrong constant or a wrong addend mode is visible on addend_o on the very cycle after the load or step. Running both modes side by side with the same engine values separates a missing word term from a wrong constant index. Holding at round 63 and stepping there shows any counter overrun at once.

// File: rtl/sha_sched_pkg.sv
package sha_sched_pkg;

    localparam int WORD_W = 32;
    localparam int K_IW   = 6;

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotr(input word_t x, input int unsigned n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    // small sigma 0 of the message expansion
    function automatic word_t ssig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    // small sigma 1 of the message expansion
    function automatic word_t ssig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    // round constant for a 6-bit round index
    function automatic word_t round_const(input logic [K_IW-1:0] idx);
        word_t k;
        case (idx)
            6'd0:  k = 32'h428a2f98;  6'd1:  k = 32'h71374491;
            6'd2:  k = 32'hb5c0fbcf;  6'd3:  k = 32'he9b5dba5;
            6'd4:  k = 32'h3956c25b;  6'd5:  k = 32'h59f111f1;
            6'd6:  k = 32'h923f82a4;  6'd7:  k = 32'hab1c5ed5;
            6'd8:  k = 32'hd807aa98;  6'd9:  k = 32'h12835b01;
            6'd10: k = 32'h243185be;  6'd11: k = 32'h550c7dc3;
            6'd12: k = 32'h72be5d74;  6'd13: k = 32'h80deb1fe;
            6'd14: k = 32'h9bdc06a7;  6'd15: k = 32'hc19bf174;
            6'd16: k = 32'he49b69c1;  6'd17: k = 32'hefbe4786;
            6'd18: k = 32'h0fc19dc6;  6'd19: k = 32'h240ca1cc;
            6'd20: k = 32'h2de92c6f;  6'd21: k = 32'h4a7484aa;
            6'd22: k = 32'h5cb0a9dc;  6'd23: k = 32'h76f988da;
            6'd24: k = 32'h983e5152;  6'd25: k = 32'ha831c66d;
            6'd26: k = 32'hb00327c8;  6'd27: k = 32'hbf597fc7;
            6'd28: k = 32'hc6e00bf3;  6'd29: k = 32'hd5a79147;
            6'd30: k = 32'h06ca6351;  6'd31: k = 32'h14292967;
            6'd32: k = 32'h27b70a85;  6'd33: k = 32'h2e1b2138;
            6'd34: k = 32'h4d2c6dfc;  6'd35: k = 32'h53380d13;
            6'd36: k = 32'h650a7354;  6'd37: k = 32'h766a0abb;
            6'd38: k = 32'h81c2c92e;  6'd39: k = 32'h92722c85;
            6'd40: k = 32'ha2bfe8a1;  6'd41: k = 32'ha81a664b;
            6'd42: k = 32'hc24b8b70;  6'd43: k = 32'hc76c51a3;
            6'd44: k = 32'hd192e819;  6'd45: k = 32'hd6990624;
            6'd46: k = 32'hf40e3585;  6'd47: k = 32'h106aa070;
            6'd48: k = 32'h19a4c116;  6'd49: k = 32'h1e376c08;
            6'd50: k = 32'h2748774c;  6'd51: k = 32'h34b0bcb5;
            6'd52: k = 32'h391c0cb3;  6'd53: k = 32'h4ed8aa4a;
            6'd54: k = 32'h5b9cca4f;  6'd55: k = 32'h682e6ff3;
            6'd56: k = 32'h748f82ee;  6'd57: k = 32'h78a5636f;
            6'd58: k = 32'h84c87814;  6'd59: k = 32'h8cc70208;
            6'd60: k = 32'h90befffa;  6'd61: k = 32'ha4506ceb;
            6'd62: k = 32'hbef9a3f7;  default: k = 32'hc67178f2;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sched_window.sv
// Sixteen-word flop window. Entry DEPTH-1 is the current round's word,
// entry DEPTH-2 the next one; new words enter at entry 0.
module sched_window
    import sha_sched_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  adv,
    input  logic [DEPTH*WORD_W-1:0] msg,
    output word_t                 tap_now,
    output word_t                 tap_next
);
    // fixed taps, relative to the word in use w[t] at entry DEPTH-1
    localparam int T_NOW  = DEPTH - 1;   // w[t]
    localparam int T_NEXT = DEPTH - 2;   // w[t+1]
    localparam int T_MID  = DEPTH - 10;  // w[t+9]
    localparam int T_FAR  = 1;           // w[t+14]

    word_t win [DEPTH];
    word_t fresh;

    // w[t+16] from fixed positions only
    always_comb begin
        fresh = ssig1(win[T_FAR]) + win[T_MID] + ssig0(win[T_NEXT]) + win[T_NOW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) win[i] <= '0;
        end else if (load) begin
            // word j of the block lands at entry DEPTH-1-j
            for (int i = 0; i < DEPTH; i++) win[i] <= msg[WORD_W*i +: WORD_W];
        end else if (adv) begin
            for (int i = DEPTH - 1; i > 0; i--) win[i] <= win[i-1];
            win[0] <= fresh;
        end
    end

    assign tap_now  = win[T_NOW];
    assign tap_next = win[T_NEXT];

endmodule

// File: rtl/sched_round_ctr.sv
module sched_round_ctr #(
    parameter int ROUNDS = 64,
    parameter int RND_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic [RND_W-1:0] round,
    output logic             last
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

    logic [RND_W-1:0] round_q;

    always_ff @(posedge clk) begin
        if (rst)       round_q <= '0;
        else if (load) round_q <= '0;
        else if (adv)  round_q <= round_q + RND_W'(1);
    end

    assign round = round_q;
    assign last  = (round_q == LAST_RND);

endmodule

// File: rtl/sched_addend.sv
// Registered addend: next h plus constant, plus the next word in mode 2.
module sched_addend
    import sha_sched_pkg::*;
#(
    parameter int LOOKAHEAD = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  upd,
    input  word_t nxt_h,
    input  word_t k_val,
    input  word_t w_in,
    output word_t addend
);
    localparam bit WITH_WORD = (LOOKAHEAD == 2);

    word_t w_term;
    word_t sum;
    word_t addend_q;

    assign w_term = WITH_WORD ? w_in : '0;
    assign sum    = nxt_h + k_val + w_term;

    always_ff @(posedge clk) begin
        if (rst)      addend_q <= '0;
        else if (upd) addend_q <= sum;
    end

    assign addend = addend_q;

endmodule

// File: rtl/sha_sched_lookahead.sv
module sha_sched_lookahead
    import sha_sched_pkg::*;
#(
    parameter int MSG_WORDS = 16,
    parameter int ROUNDS    = 64,
    parameter int RND_W     = 8,
    parameter int LOOKAHEAD = 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load_i,
    input  logic [MSG_WORDS*WORD_W-1:0]   msg_i,
    input  logic                          step_i,
    input  logic [WORD_W-1:0]             nxt_h_i,
    output logic [WORD_W-1:0]             word_o,
    output logic [RND_W-1:0]              round_o,
    output logic [WORD_W-1:0]             addend_o
);
    localparam int MSG_W = MSG_WORDS * WORD_W;

    logic             last;
    logic             adv;
    logic             upd;
    logic [RND_W-1:0] round;
    logic [K_IW-1:0]  k_sel;
    word_t            tap_now;
    word_t            tap_next;
    word_t            w_enter;
    word_t            k_val;

    // load wins over step; a step on the last round is dropped
    assign adv = step_i && !load_i && !last;
    assign upd = load_i || adv;

    // constant and word of the round being entered
    assign k_sel   = load_i ? '0 : (round[K_IW-1:0] + K_IW'(1));
    assign k_val   = round_const(k_sel);
    assign w_enter = load_i ? msg_i[MSG_W-1 -: WORD_W] : tap_next;

    sched_window #(
        .DEPTH (MSG_WORDS)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .adv      (adv),
        .msg      (msg_i),
        .tap_now  (tap_now),
        .tap_next (tap_next)
    );

    sched_round_ctr #(
        .ROUNDS (ROUNDS),
        .RND_W  (RND_W)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .load  (load_i),
        .adv   (adv),
        .round (round),
        .last  (last)
    );

    sched_addend #(
        .LOOKAHEAD (LOOKAHEAD)
    ) u_add (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .nxt_h  (nxt_h_i),
        .k_val  (k_val),
        .w_in   (w_enter),
        .addend (addend_o)
    );

    assign word_o  = tap_now;
    assign round_o = round;

endmodule

// File: rtl/sched_chk.sv
module sched_chk
    import sha_sched_pkg::*;
#(
    parameter int ROUNDS    = 64,
    parameter int RND_W     = 8,
    parameter int LOOKAHEAD = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              load_i,
    input logic              step_i,
    input logic [WORD_W-1:0] msg_w0,
    input logic [WORD_W-1:0] nxt_h_i,
    input logic [WORD_W-1:0] word_o,
    input logic [RND_W-1:0]  round_o,
    input logic [WORD_W-1:0] addend_o
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);
    localparam bit WITH_WORD = (LOOKAHEAD == 2);

    // R2
    load_start_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (round_o == '0) && (word_o == $past(msg_w0)));

    // R5
    round_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o != LAST_RND) |=> round_o == $past(round_o) + RND_W'(1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(word_o) && $stable(round_o) && $stable(addend_o));

    // R6
    last_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o == LAST_RND) |=>
            $stable(word_o) && $stable(round_o) && $stable(addend_o));

    // R6
    round_range_chk: assert property (@(posedge clk) disable iff (rst)
        round_o <= LAST_RND);

    // R8 R9
    load_addend_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> addend_o == $past(nxt_h_i) + round_const('0) + (WITH_WORD ? word_o : '0));

    // R8 R9
    step_addend_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o != LAST_RND) |=>
            addend_o == $past(nxt_h_i) + round_const(round_o[K_IW-1:0]) + (WITH_WORD ? word_o : '0));

endmodule

bind sha_sched_lookahead sched_chk #(
    .ROUNDS    (ROUNDS),
    .RND_W     (RND_W),
    .LOOKAHEAD (LOOKAHEAD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_i),
    .step_i   (step_i),
    .msg_w0   (msg_i[MSG_WORDS*32-1 -: 32]),
    .nxt_h_i  (nxt_h_i),
    .word_o   (word_o),
    .round_o  (round_o),
    .addend_o (addend_o)
);

// File: tb/sim_sha_sched_lookahead.sv
`timescale 1ns/1ps
module sim_sha_sched_lookahead;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_i;
    logic         step_i;
    logic [511:0] msg_i;
    logic [31:0]  nxt_h_i;
    logic [31:0]  w0, w1, a0, a1;
    logic [7:0]   r0, r1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sha_sched_lookahead #(.LOOKAHEAD(1)) u0 (
        .clk(clk), .rst(rst), .load_i(load_i), .msg_i(msg_i), .step_i(step_i),
        .nxt_h_i(nxt_h_i), .word_o(w0), .round_o(r0), .addend_o(a0));

    sha_sched_lookahead #(.LOOKAHEAD(2)) u1 (
        .clk(clk), .rst(rst), .load_i(load_i), .msg_i(msg_i), .step_i(step_i),
        .nxt_h_i(nxt_h_i), .word_o(w1), .round_o(r1), .addend_o(a1));

    // reference model state
    int          mr;
    logic [31:0] ms [64];
    logic [31:0] kref [64];
    logic [31:0] mp1, mp2;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // R10: constants from cube roots of the first 64 primes
    task automatic build_k();
        int found;
        found = 0;
        for (int n = 2; found < 64; n++) begin
            bit  pr;
            real c;
            real f;
            pr = 1;
            for (int d = 2; d * d <= n; d++) if (n % d == 0) pr = 0;
            if (pr) begin
                c = $pow(real'(n), 1.0 / 3.0);
                repeat (3) c = c - (c * c * c - real'(n)) / (3.0 * c * c);
                f = c - $floor(c);
                kref[found] = 32'(longint'($floor(f * 4294967296.0)));
                found++;
            end
        end
    endtask

    task automatic expand(input logic [511:0] m);
        for (int t = 0; t < 16; t++) ms[t] = m[511 - 32 * t -: 32];
        for (int t = 16; t < 64; t++) begin
            logic [31:0] s0, s1;
            s0 = rr(ms[t-15], 7) ^ rr(ms[t-15], 18) ^ (ms[t-15] >> 3);
            s1 = rr(ms[t-2], 17) ^ rr(ms[t-2], 19) ^ (ms[t-2] >> 10);
            ms[t] = s1 + ms[t-7] + s0 + ms[t-16];
        end
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (model round %0d)",
                     req, what, act, exp, mr);
        end
    endtask

    task automatic check_all(input string wtag, input string k1tag);
        string t;
        t = (wtag == "auto") ? ((mr == 0) ? "R2" : (mr < 16) ? "R3" : "R4") : wtag;
        chk(w0, ms[mr], t, "mode1 word");
        chk(w1, ms[mr], t, "mode2 word");
        chk({24'd0, r0}, 32'(mr), t, "mode1 round");
        chk({24'd0, r1}, 32'(mr), t, "mode2 round");
        chk(a0, mp1, k1tag, "mode1 addend");
        chk(a1, mp2, (wtag == "auto") ? "R9" : wtag, "mode2 addend");
    endtask

    function automatic logic [31:0] nexth();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // one cycle: drive at negedge, update model, sample at next negedge
    task automatic cyc(input logic ld, input logic st, input logic [511:0] m,
                       input logic [31:0] nh, input string wtag, input string k1tag);
        load_i = ld; step_i = st; msg_i = m; nxt_h_i = nh;
        if (ld) begin
            mr = 0;
            expand(m);
            mp1 = nh + kref[0];
            mp2 = mp1 + ms[0];
        end else if (st && mr < 63) begin
            mp1 = nh + kref[mr + 1];
            mp2 = mp1 + ms[mr + 1];
            mr++;
        end
        @(posedge clk);
        @(negedge clk);
        check_all(wtag, k1tag);
    endtask

    task automatic model_zero();
        mr = 0; mp1 = '0; mp2 = '0;
        for (int t = 0; t < 64; t++) ms[t] = '0;
    endtask

    logic [511:0] msg_abc, msg_b, msg_c;

    initial begin
        rst = 1'b1; load_i = 0; step_i = 0; msg_i = '0; nxt_h_i = '0;
        build_k();
        model_zero();
        msg_abc = '0;
        msg_abc[511:480] = 32'h61626380;
        msg_abc[31:0]    = 32'h00000018;
        for (int j = 0; j < 16; j++) begin
            msg_b[511 - 32 * j -: 32] = (32'(j) + 32'd1) * 32'h9e3779b9;
            msg_c[511 - 32 * j -: 32] = ~(32'(j) * 32'h7f4a7c15) ^ 32'h0f0f0f0f;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_all("R1", "R1");
        rst = 1'b0;
        cyc(0, 0, '0, 32'hdead_beef, "R1", "R1");

        // R2 load, then R3/R4 run with idle gaps (R5)
        cyc(1, 0, msg_abc, nexth(), "R2", "R8");
        for (int s = 1; s <= 63; s++) begin
            cyc(0, 1, '0, nexth(), "auto", "R8");
            if (mr == 16) chk(w0, 32'h61626380, "R4", "known word 16");
            if (s % 7 == 0) cyc(0, 0, '0, nexth(), "R5", "R5");
        end
        // R6: steps on the last round are ignored
        repeat (3) cyc(0, 1, '0, nexth(), "R6", "R6");

        // R7: load with step in the same cycle; R10 with zero h
        cyc(1, 1, msg_b, 32'd0, "R7", "R7");
        chk(a0, kref[0], "R10", "K0 direct");
        for (int s = 0; s < 20; s++) cyc(0, 1, '0, 32'd0, "auto", "R10");

        // R11: reset beats load and step
        rst = 1'b1;
        model_zero();
        load_i = 1; step_i = 1; msg_i = msg_c; nxt_h_i = nexth();
        @(posedge clk);
        @(negedge clk);
        check_all("R11", "R11");
        rst = 1'b0;

        // third block, stepped every cycle to the end
        cyc(1, 0, msg_c, nexth(), "R2", "R8");
        for (int s = 0; s < 66; s++) cyc(0, 1, '0, nexth(), "auto", "R8");
        cyc(0, 0, '0, nexth(), "R5", "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule